// File: doc/BRIEF.md
# Lane Word-Synchronization Monitor

This block judges whether a receive lane holds word synchronization. Upstream logic has already aligned the stream. Each clock it presents at most one code group, described by three indications: a valid strobe, a flag raised when the group matched the alignment pattern or its bitwise complement, and a flag raised when the group was erroneous. The block turns these indications into a single registered `sync_status` level.

While hunting, the block counts synchronization groups until a programmable acquisition threshold is reached. Once locked, it keeps an error count that each erroneous group raises. Each run of a programmable number of consecutive good groups lowers that count by one. Lock is lost when the count reaches a programmable loss threshold, and the hunt then starts over from zero.

The group interface carries no back-pressure. The block accepts every valid group in the cycle it is presented, so it has no ready output. A producer may stall by holding `grp_valid` low for any number of cycles, and a stalled cycle changes nothing. The thresholds are sampled only while reset is asserted.

Top module: `lane_sync_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sync_status` becomes 0, all counters clear, and the three threshold inputs are captured.
- R2: `cfg_acq_m1` holds A-1, where A runs from 1 to 256. While hunting, the A-th valid synchronization group (sync flag 1, error flag 0) makes `sync_status` 1 on the clock edge that accepts it. The sync flag stands for a match to either the pattern or its complement.
- R3: While hunting, a valid erroneous group resets the acquisition count to zero. A valid group with neither flag set leaves the count unchanged.
- R4: `cfg_loss_m1` holds L-1, where L runs from 1 to 64. While locked, each valid erroneous group raises the error count by one and clears the good run. The group that brings the count to L drops `sync_status` on the edge that accepts it.
- R5: `cfg_good_m1` holds G-1, where G runs from 1 to 256. While locked with a nonzero error count, each valid non-erroneous group extends the good run. The G-th group in the run lowers the error count by one and restarts the run.
- R6: While locked with an error count of zero, good groups build no run, so no credit is stored and the error count never goes below zero.
- R7: A loss of lock clears the error, good-run and acquisition counts. Regaining lock requires A fresh synchronization groups.
- R8: A group that has both the sync flag and the error flag set is treated as erroneous.
- R9: Cycles with `grp_valid` low change neither `sync_status` nor any count.
- R10: Changes on the threshold inputs while `rst_n` is high have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; thresholds are captured while it is low |
| cfg_acq_m1 | input | 8 | Acquisition threshold minus one |
| cfg_loss_m1 | input | 6 | Loss threshold minus one |
| cfg_good_m1 | input | 8 | Good-run length minus one |
| grp_valid | input | 1 | A code group is present this cycle |
| grp_is_sync | input | 1 | Group matched the alignment pattern or its complement |
| grp_is_err | input | 1 | Group is erroneous |
| sync_status | output | 1 | Lane is word-synchronized |

## Verification
The hardest state to reach is a lock that is one error away from loss. For the loss decision to be exercised in full, the good run must sit one group short of a decrement at that moment. Directed sequences build this state by interleaving errors with good runs of exactly G-1 groups, and then choose whether the next group is the error that drops lock or the good group that saves it. Two further sequences cover the edges. One drives the widest settings (256 synchronization groups, 64 errors) end to end. The other keeps changing the threshold inputs after reset while a behavioural model, which holds the latched values, is compared against the output on every clock.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lsm_state_t;
endpackage

// File: rtl/lsm_cfg.sv
// Captures the thresholds while reset is asserted and holds them afterwards.
module lsm_cfg #(
  parameter int ACQ_W  = 8,
  parameter int LOSS_W = 6,
  parameter int GOOD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACQ_W-1:0]  acq_in,
  input  logic [LOSS_W-1:0] loss_in,
  input  logic [GOOD_W-1:0] good_in,
  output logic [ACQ_W-1:0]  acq_q,
  output logic [LOSS_W-1:0] loss_q,
  output logic [GOOD_W-1:0] good_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_q  <= acq_in;
      loss_q <= loss_in;
      good_q <= good_in;
    end
  end
endmodule

// File: rtl/lsm_acquire.sv
// Counts synchronization groups while hunting; wraps to zero on completion.
module lsm_acquire #(
  parameter int ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             grp_valid,
  input  logic             grp_is_sync,
  input  logic             grp_is_err,
  input  logic [ACQ_W-1:0] thr_m1,
  output logic             done
);
  logic [ACQ_W-1:0] cnt_q;
  logic             take;

  assign take = en && grp_valid;
  assign done = take && !grp_is_err && grp_is_sync && (cnt_q == thr_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take) begin
      if (grp_is_err) begin
        cnt_q <= '0;
      end else if (grp_is_sync) begin
        cnt_q <= (cnt_q == thr_m1) ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsm_loss.sv
// Error count with good-run hysteresis while locked.
module lsm_loss #(
  parameter int LOSS_W = 6,
  parameter int GOOD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              grp_valid,
  input  logic              grp_is_err,
  input  logic [LOSS_W-1:0] loss_m1,
  input  logic [GOOD_W-1:0] good_m1,
  output logic [LOSS_W-1:0] err_level,
  output logic              loss_hit
);
  logic [LOSS_W-1:0] err_q;
  logic [GOOD_W-1:0] good_q;
  logic              take;
  logic              err_zero;

  assign take      = en && grp_valid;
  assign err_zero  = (err_q == '0);
  assign loss_hit  = take && grp_is_err && (err_q == loss_m1);
  assign err_level = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
    end else if (take) begin
      if (grp_is_err) begin
        good_q <= '0;
        err_q  <= (err_q == loss_m1) ? '0 : err_q + 1'b1;
      end else if (!err_zero) begin
        if (good_q == good_m1) begin
          good_q <= '0;
          err_q  <= err_q - 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_sync_monitor.sv
module lane_sync_monitor
  import lsm_pkg::*;
#(
  parameter int ACQ_W  = 8,
  parameter int LOSS_W = 6,
  parameter int GOOD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACQ_W-1:0]  cfg_acq_m1,
  input  logic [LOSS_W-1:0] cfg_loss_m1,
  input  logic [GOOD_W-1:0] cfg_good_m1,
  input  logic              grp_valid,
  input  logic              grp_is_sync,
  input  logic              grp_is_err,
  output logic              sync_status
);
  lsm_state_t        state_q, state_d;
  logic [ACQ_W-1:0]  acq_thr_q;
  logic [LOSS_W-1:0] loss_thr_q;
  logic [GOOD_W-1:0] good_thr_q;
  logic [LOSS_W-1:0] err_level;
  logic              acq_done;
  logic              loss_hit;
  logic              hunting;
  logic              locked;

  assign hunting = (state_q == ST_HUNT);
  assign locked  = (state_q == ST_LOCKED);

  lsm_cfg #(.ACQ_W(ACQ_W), .LOSS_W(LOSS_W), .GOOD_W(GOOD_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .acq_in  (cfg_acq_m1),
    .loss_in (cfg_loss_m1),
    .good_in (cfg_good_m1),
    .acq_q   (acq_thr_q),
    .loss_q  (loss_thr_q),
    .good_q  (good_thr_q)
  );

  lsm_acquire #(.ACQ_W(ACQ_W)) u_acq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (hunting),
    .grp_valid   (grp_valid),
    .grp_is_sync (grp_is_sync),
    .grp_is_err  (grp_is_err),
    .thr_m1      (acq_thr_q),
    .done        (acq_done)
  );

  lsm_loss #(.LOSS_W(LOSS_W), .GOOD_W(GOOD_W)) u_loss (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (locked),
    .grp_valid  (grp_valid),
    .grp_is_err (grp_is_err),
    .loss_m1    (loss_thr_q),
    .good_m1    (good_thr_q),
    .err_level  (err_level),
    .loss_hit   (loss_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:   if (acq_done) state_d = ST_LOCKED;
      ST_LOCKED: if (loss_hit) state_d = ST_HUNT;
      default:   state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_d;
  end

  assign sync_status = locked;
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int LOSS_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grp_valid,
  input logic              grp_is_sync,
  input logic              grp_is_err,
  input logic              sync_status,
  input logic [LOSS_W-1:0] err_level,
  input logic [LOSS_W-1:0] loss_thr
);
  // R2: lock is only gained on a valid, clean sync group
  assert_lock_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_status) |-> $past(grp_valid && grp_is_sync && !grp_is_err));

  // R4 / R8: lock is only lost on a valid erroneous group
  assert_loss_on_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_status) |-> $past(grp_valid && grp_is_err));

  // R4: the error count stays below the loss threshold
  assert_err_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_level <= loss_thr);

  // R7: the error count is clear right after a loss
  assert_cleared_after_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_status) |-> (err_level == '0));

  // R9: idle cycles change nothing visible
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |=> ($stable(sync_status) && $stable(err_level)));

  // R6: no error count outside lock
  assert_no_err_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_status |-> (err_level == '0));
endmodule

bind lane_sync_monitor lsm_checker #(.LOSS_W(LOSS_W)) u_lsm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .grp_valid   (grp_valid),
  .grp_is_sync (grp_is_sync),
  .grp_is_err  (grp_is_err),
  .sync_status (sync_status),
  .err_level   (err_level),
  .loss_thr    (loss_thr_q)
);

// File: tb/tb_lane_sync_monitor.sv
`timescale 1ns/1ps
module tb_lane_sync_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_acq_m1 = 8'd0;
  logic [5:0] cfg_loss_m1 = 6'd0;
  logic [7:0] cfg_good_m1 = 8'd0;
  logic       grp_valid = 1'b0;
  logic       grp_is_sync = 1'b0;
  logic       grp_is_err = 1'b0;
  logic       sync_status;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural reference state
  int m_lock, m_acq, m_err, m_good;
  int thr_a, thr_l, thr_g;
  int lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;  // 250 MHz

  lane_sync_monitor dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_acq_m1(cfg_acq_m1), .cfg_loss_m1(cfg_loss_m1), .cfg_good_m1(cfg_good_m1),
    .grp_valid(grp_valid), .grp_is_sync(grp_is_sync), .grp_is_err(grp_is_err),
    .sync_status(sync_status)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input string tag);
    tests++;
    if (sync_status !== m_lock[0]) begin
      fails++;
      $display("FAIL %s: sync_status actual %0b expected %0b (cycle %0d)",
               tag, sync_status, m_lock[0], cycles);
    end
  endtask

  task automatic do_reset(input int a, input int l, input int g);
    @(negedge clk);
    rst_n = 1'b0;
    grp_valid = 1'b0; grp_is_sync = 1'b0; grp_is_err = 1'b0;
    cfg_acq_m1 = 8'(a - 1); cfg_loss_m1 = 6'(l - 1); cfg_good_m1 = 8'(g - 1);
    thr_a = a; thr_l = l; thr_g = g;
    m_lock = 0; m_acq = 0; m_err = 0; m_good = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1");
  endtask

  task automatic model(input bit v, input bit s, input bit e);
    if (!v) return;
    if (m_lock == 0) begin
      if (e) m_acq = 0;
      else if (s) begin
        m_acq++;
        if (m_acq == thr_a) begin m_lock = 1; m_acq = 0; end
      end
    end else begin
      if (e) begin
        m_good = 0; m_err++;
        if (m_err == thr_l) begin m_lock = 0; m_err = 0; m_acq = 0; end
      end else if (m_err > 0) begin
        m_good++;
        if (m_good == thr_g) begin m_good = 0; m_err--; end
      end
    end
  endtask

  task automatic step(input bit v, input bit s, input bit e, input string tag);
    @(negedge clk);
    grp_valid = v; grp_is_sync = s; grp_is_err = e;
    model(v, s, e);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic rep(input int n, input bit v, input bit s, input bit e, input string tag);
    for (int i = 0; i < n; i++) step(v, s, e, tag);
  endtask

  task automatic rnd_run(input int n, input int err_mod, input string tag);
    for (int i = 0; i < n; i++) begin
      lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C1_1DB7 : 0);
      step(lfsr[3:0] != 0, lfsr[6:4] != 0, (lfsr[15:8] % err_mod) == 0, tag);
    end
  endtask

  task automatic expect_lock(input int exp, input string tag);
    tests++;
    if (sync_status !== exp[0]) begin
      fails++;
      $display("FAIL %s: directed sync_status actual %0b expected %0b", tag, sync_status, exp[0]);
    end
  endtask

  initial begin
    // R1, R2, R3: acquisition with an interrupting error
    do_reset(3, 4, 2);
    rep(2, 1, 1, 0, "R2");
    step(1, 0, 0, "R3");          // neither flag: count held
    step(1, 1, 1, "R8");          // both flags: error, clears count
    rep(2, 1, 1, 0, "R3");
    expect_lock(0, "R3");
    step(1, 1, 0, "R2");
    expect_lock(1, "R2");

    // R9: invalid groups with flags set
    rep(5, 0, 0, 1, "R9");
    expect_lock(1, "R9");

    // R4, R5: hysteresis, errors separated by runs one short of a decrement
    step(1, 0, 1, "R4");
    step(1, 0, 0, "R5");          // run 1 of 2
    step(1, 0, 1, "R4");          // clears run, err = 2
    step(1, 0, 0, "R5");
    step(1, 0, 0, "R5");          // decrement, err = 1
    step(1, 0, 1, "R4");
    step(1, 0, 1, "R4");
    step(1, 0, 0, "R5");          // err = 3, one short
    step(1, 0, 1, "R4");          // err = 4 -> loss
    expect_lock(0, "R4");

    // R7: fresh acquisition needed after loss
    rep(2, 1, 1, 0, "R7");
    expect_lock(0, "R7");
    step(1, 1, 0, "R7");
    expect_lock(1, "R7");

    // R6: long good stretch at zero errors stores no credit
    rep(20, 1, 1, 0, "R6");
    rep(3, 1, 0, 1, "R6");
    step(1, 0, 1, "R6");
    expect_lock(0, "R6");

    // minimum settings
    do_reset(1, 1, 1);
    step(1, 1, 0, "R2");
    expect_lock(1, "R2");
    step(1, 0, 1, "R4");
    expect_lock(0, "R4");
    rnd_run(2000, 5, "R5");

    // maximum settings
    do_reset(256, 64, 256);
    rep(255, 1, 1, 0, "R2");
    expect_lock(0, "R2");
    step(1, 1, 0, "R2");
    expect_lock(1, "R2");
    rep(63, 1, 0, 1, "R4");
    rep(255, 1, 0, 0, "R5");
    expect_lock(1, "R5");
    step(1, 0, 0, "R5");          // err 63 -> 62
    step(1, 0, 1, "R4");          // back to 63
    step(1, 0, 1, "R4");          // 64 -> loss
    expect_lock(0, "R4");

    // R10: threshold inputs change after reset; latched values stay
    do_reset(4, 3, 5);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_acq_m1 = 8'(k * 37); cfg_loss_m1 = 6'(k * 11); cfg_good_m1 = 8'(k * 53);
      rnd_run(600, 9, "R10");
    end
    rnd_run(3000, 4, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule